// File: doc/BRIEF.md
# Asynchronous Host Register Interface

This block lets a host processor with its own clock read and write a small register file that lives in the system clock domain. The host chooses one of two register spaces by pulling one of two active-low selects low: one select opens the port/chip space, the other opens the system space. It puts an address on an 8-bit bus and sets the direction with an active-low write strobe. Data travels on a 16-bit bidirectional bus.

Every access is handshaked through a ready line. Ready drops as soon as a select goes low, without waiting for a clock. It rises on the first system clock edge that finds the select low. That same edge commits a write, or latches read data onto the bus. The read data stays on the bus until the select is released.

The block also raises an active-low interrupt from four condition inputs. Each condition has its own enable bit. Each pending condition is cleared by a read of the register tied to it.

Top module: `hreg_async_if`

## Requirements
- R1: After reset, `irq_n` is high and every register reads back as zero.
- R2: `hrdy` goes low as soon as either select goes low, before any system clock edge occurs.
- R3: `hrdy` goes high on the first rising `clk` edge at which a select is low, and stays high for the rest of that access.
- R4: With `wr_n` low, the value on `hdata` is stored in the register chosen by `addr` in the selected space. A later read with `wr_n` high returns that value.
- R5: The two spaces are independent. Writing address A through `sel_port_n` leaves address A of the space reached through `sel_sys_n` unchanged, and the reverse holds too.
- R6: When both selects are low together, the access goes to the port/chip space.
- R7: An address at or above `N_REGS` reads as zero, and a write to it changes no register. All 8 address bits are compared.
- R8: The block drives `hdata` only during a read, after `hrdy` has risen, and only while a select is low. At all other times the bus is left to the host.
- R9: A one-cycle pulse on `cond_i[k]` sets pending condition k only if bit k of system-space register 0 is 1. `irq_n` goes low on the `clk` edge that samples the pulse.
- R10: A read of port-space register k clears pending condition k. A read of any other register leaves it pending.
- R11: `irq_n` stays low while any condition is pending, and returns high only after every pending condition has been cleared.
- R12: Read data stays stable on `hdata` for as long as the select is held low after `hrdy` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_port_n | input | 1 | Active-low select for the port/chip register space |
| sel_sys_n | input | 1 | Active-low select for the system register space |
| wr_n | input | 1 | Low selects a write, high selects a read |
| addr | input | ADDR_W (8) | Register address |
| hdata | inout | DATA_W (16) | Tri-state host data bus |
| hrdy | output | 1 | Access ready: low while waiting, high when done; high impedance when no select is low |
| irq_n | output | 1 | Active-low interrupt |
| cond_i | input | IRQ_N (4) | Interrupt condition pulses from the core |

## Verification
The bench builds the block with `N_REGS` = 6 instead of the default 8. This leaves addresses 6 and 7 unused inside the low address bits, so the out-of-range rule can be tested on addresses that share index bits with real registers. The other parameters keep their default values. With four conditions and six port registers, the bench can test that reading a register not tied to any condition leaves pending interrupts set.

// File: rtl/hreg_pkg.sv
package hreg_pkg;
   typedef enum logic {
      SP_PORT = 1'b0,
      SP_SYS  = 1'b1
   } space_e;
endpackage

// File: rtl/hreg_handshake.sv
// Access handshake: ready flop is cleared asynchronously while idle
// and set by the first system clock edge that finds a select low.
module hreg_handshake (
   input  logic clk,
   input  logic rst_n,
   input  logic acc_n,
   output logic done,
   output logic go
);
   logic idle;
   assign idle = acc_n | ~rst_n;

   always_ff @(posedge clk or posedge idle) begin
      if (idle) done <= 1'b0;
      else      done <= 1'b1;
   end

   // one-cycle window: select low, ready not yet released
   assign go = ~acc_n & ~done & rst_n;
endmodule

// File: rtl/hreg_file.sv
module hreg_file #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned N_REGS = 8,
   parameter int unsigned IRQ_N  = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 go,
   input  logic                 wr,
   input  hreg_pkg::space_e     space,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [DATA_W-1:0]    wdata,
   output logic [DATA_W-1:0]    rdata,
   output logic [IRQ_N-1:0]     en,
   output logic [IRQ_N-1:0]     rd_hit
);
   localparam int unsigned IDX_W = (N_REGS > 1) ? $clog2(N_REGS) : 1;

   logic [DATA_W-1:0] mem [2][N_REGS];
   logic              in_range;
   logic [IDX_W-1:0]  idx;
   logic              sp;

   assign in_range = (addr < ADDR_W'(N_REGS));
   assign idx      = addr[IDX_W-1:0];
   assign sp       = (space == hreg_pkg::SP_SYS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < 2; s++)
            for (int r = 0; r < N_REGS; r++)
               mem[s][r] <= '0;
      end else begin
         for (int s = 0; s < 2; s++)
            for (int r = 0; r < N_REGS; r++)
               if (go && wr && in_range && (sp == s[0]) && (idx == r[IDX_W-1:0]))
                  mem[s][r] <= wdata;
      end
   end

   assign rdata = in_range ? mem[sp][idx] : '0;
   assign en    = mem[1][0][IRQ_N-1:0];

   for (genvar k = 0; k < IRQ_N; k++) begin : g_hit
      assign rd_hit[k] = go & ~wr & in_range & ~sp & (idx == IDX_W'(k));
   end
endmodule

// File: rtl/hreg_irq.sv
module hreg_irq #(
   parameter int unsigned IRQ_N = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IRQ_N-1:0] cond_i,
   input  logic [IRQ_N-1:0] en,
   input  logic [IRQ_N-1:0] rd_hit,
   output logic [IRQ_N-1:0] pend,
   output logic             irq_n
);
   for (genvar k = 0; k < IRQ_N; k++) begin : g_pend
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                 pend[k] <= 1'b0;
         else if (cond_i[k] & en[k]) pend[k] <= 1'b1;   // set wins over clear
         else if (rd_hit[k])         pend[k] <= 1'b0;
      end
   end

   assign irq_n = ~|pend;
endmodule

// File: rtl/hreg_async_if.sv
module hreg_async_if #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned N_REGS = 8,
   parameter int unsigned IRQ_N  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_port_n,
   input  logic              sel_sys_n,
   input  logic              wr_n,
   input  logic [ADDR_W-1:0] addr,
   inout  wire  [DATA_W-1:0] hdata,
   output logic              hrdy,
   output logic              irq_n,
   input  logic [IRQ_N-1:0]  cond_i
);
   if (N_REGS < IRQ_N)        begin : g_err_regs  $error("N_REGS must cover IRQ_N"); end
   if (DATA_W < IRQ_N)        begin : g_err_width $error("DATA_W must hold IRQ_N enable bits"); end
   if (N_REGS >= (1 << ADDR_W)) begin : g_err_addr $error("N_REGS must fit below 2**ADDR_W"); end

   logic                acc_n, done, go, wr;
   hreg_pkg::space_e    space;
   logic [DATA_W-1:0]   rdata, rd_q;
   logic                rd_act, bus_oe;
   logic [IRQ_N-1:0]    irq_en, rd_hit, pend;

   assign acc_n = sel_port_n & sel_sys_n;
   assign space = (!sel_port_n) ? hreg_pkg::SP_PORT : hreg_pkg::SP_SYS;
   assign wr    = ~wr_n;

   hreg_handshake u_hs (
      .clk  (clk),
      .rst_n(rst_n),
      .acc_n(acc_n),
      .done (done),
      .go   (go)
   );

   hreg_file #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_REGS(N_REGS), .IRQ_N(IRQ_N)
   ) u_file (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (go),
      .wr    (wr),
      .space (space),
      .addr  (addr),
      .wdata (hdata),
      .rdata (rdata),
      .en    (irq_en),
      .rd_hit(rd_hit)
   );

   hreg_irq #(.IRQ_N(IRQ_N)) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .cond_i(cond_i),
      .en    (irq_en),
      .rd_hit(rd_hit),
      .pend  (pend),
      .irq_n (irq_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q   <= '0;
         rd_act <= 1'b0;
      end else if (go) begin
         rd_q   <= rdata;
         rd_act <= ~wr;
      end
   end

   assign bus_oe = ~acc_n & done & rd_act;
   assign hdata  = bus_oe ? rd_q : 'z;
   assign hrdy   = acc_n ? 1'bz : done;
endmodule

// File: rtl/hreg_async_if_chk.sv
module hreg_async_if_chk #(
   parameter int unsigned IRQ_N = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             acc_n,
   input logic             go,
   input logic             done,
   input logic             oe,
   input logic [IRQ_N-1:0] cond_i,
   input logic [IRQ_N-1:0] en,
   input logic             irq_n
);
   p_irq_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (|(cond_i & en)) |=> !irq_n);

   p_irq_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_n && !go) |=> !irq_n);

   p_rdy_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
      go |=> (done || acc_n));

   p_single_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      go |=> !go);

   p_no_drive_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      acc_n |-> !oe);
endmodule

bind hreg_async_if hreg_async_if_chk #(.IRQ_N(IRQ_N)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .acc_n (acc_n),
   .go    (go),
   .done  (done),
   .oe    (bus_oe),
   .cond_i(cond_i),
   .en    (irq_en),
   .irq_n (irq_n)
);

// File: tb/hreg_async_if_tb_top.sv
`timescale 1ns/100ps
module hreg_async_if_tb_top;
   localparam int NR = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel_port_n = 1'b1;
   logic        sel_sys_n = 1'b1;
   logic        wr_n = 1'b1;
   logic [7:0]  addr = '0;
   logic [3:0]  cond_i = '0;
   logic        drv = 1'b0;
   logic [15:0] drv_val = '0;
   wire  [15:0] hdata;
   wire         hrdy;
   wire         irq_n;

   int total = 0;
   int bad   = 0;

   assign hdata = drv ? drv_val : 'z;

   always #2 clk = ~clk;

   hreg_async_if #(.N_REGS(NR)) dut_i (
      .clk(clk), .rst_n(rst_n), .sel_port_n(sel_port_n), .sel_sys_n(sel_sys_n),
      .wr_n(wr_n), .addr(addr), .hdata(hdata), .hrdy(hrdy), .irq_n(irq_n),
      .cond_i(cond_i)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // spc: 0 = port select, 1 = system select, 2 = both selects
   task automatic access(input int spc, input bit wr, input logic [7:0] a,
                         input logic [15:0] wd, output logic [15:0] rd);
      @(negedge clk);
      addr = a;
      wr_n = ~wr;
      drv = wr;
      drv_val = wd;
      sel_port_n = !(spc == 0 || spc == 2);
      sel_sys_n  = !(spc == 1 || spc == 2);
      #1;
      chk("R2 ready low before edge", {31'd0, hrdy}, 32'd0);
      @(posedge clk);
      #1;
      chk("R3 ready high after first edge", {31'd0, hrdy}, 32'd1);
      rd = hdata;
      if (!wr) begin
         repeat (2) @(posedge clk);
         #1;
         chk("R12 read data held", {16'd0, hdata}, {16'd0, rd});
         chk("R3 ready stays high", {31'd0, hrdy}, 32'd1);
      end else begin
         chk("R8 no drive during write", {16'd0, hdata}, {16'd0, wd});
      end
      @(negedge clk);
      sel_port_n = 1'b1;
      sel_sys_n  = 1'b1;
      drv = 1'b0;
      wr_n = 1'b1;
   endtask

   task automatic pulse(input logic [3:0] v);
      @(negedge clk);
      cond_i = v;
      @(negedge clk);
      cond_i = '0;
   endtask

   task automatic t_reset();
      logic [15:0] r;
      chk("R1 irq idle after reset", {31'd0, irq_n}, 32'd1);
      access(0, 0, 8'd2, 16'h0, r);
      chk("R1 port reg zero", {16'd0, r}, 32'd0);
      access(1, 0, 8'd0, 16'h0, r);
      chk("R1 sys reg zero", {16'd0, r}, 32'd0);
   endtask

   task automatic t_rw();
      logic [15:0] r;
      access(0, 1, 8'd2, 16'h1234, r);
      access(1, 1, 8'd3, 16'hABCD, r);
      access(0, 0, 8'd2, 16'h0, r);
      chk("R4 port readback", {16'd0, r}, 32'h1234);
      access(1, 0, 8'd3, 16'h0, r);
      chk("R4 sys readback", {16'd0, r}, 32'hABCD);
      access(0, 1, 8'd3, 16'h1111, r);
      access(1, 0, 8'd3, 16'h0, r);
      chk("R5 sys untouched by port write", {16'd0, r}, 32'hABCD);
      access(0, 0, 8'd3, 16'h0, r);
      chk("R5 port reg 3", {16'd0, r}, 32'h1111);
   endtask

   task automatic t_both();
      logic [15:0] r;
      access(2, 1, 8'd1, 16'h7777, r);
      access(0, 0, 8'd1, 16'h0, r);
      chk("R6 both selects hit port space", {16'd0, r}, 32'h7777);
      access(1, 0, 8'd1, 16'h0, r);
      chk("R6 sys space untouched", {16'd0, r}, 32'h0);
   endtask

   task automatic t_range();
      logic [15:0] r;
      access(0, 1, 8'd6, 16'hFFFF, r);
      access(0, 0, 8'd6, 16'h0, r);
      chk("R7 out of range reads zero", {16'd0, r}, 32'h0);
      access(0, 1, 8'h82, 16'h5555, r);
      access(0, 0, 8'd2, 16'h0, r);
      chk("R7 high address bits compared", {16'd0, r}, 32'h1234);
   endtask

   task automatic t_float();
      @(negedge clk);
      drv = 1'b1;
      drv_val = 16'h5AC3;
      #1;
      chk("R8 bus free when idle", {16'd0, hdata}, 32'h5AC3);
      @(negedge clk);
      drv = 1'b0;
   endtask

   task automatic t_irq();
      logic [15:0] r;
      access(1, 1, 8'd0, 16'h0005, r);
      pulse(4'b0010);
      chk("R9 disabled condition ignored", {31'd0, irq_n}, 32'd1);
      pulse(4'b0001);
      chk("R9 enabled condition raises irq", {31'd0, irq_n}, 32'd0);
      access(0, 0, 8'd1, 16'h0, r);
      chk("R10 other read keeps pending", {31'd0, irq_n}, 32'd0);
      access(0, 0, 8'd0, 16'h0, r);
      chk("R10 tied read clears", {31'd0, irq_n}, 32'd1);
      pulse(4'b0101);
      chk("R11 two pending", {31'd0, irq_n}, 32'd0);
      access(0, 0, 8'd0, 16'h0, r);
      chk("R11 one still pending", {31'd0, irq_n}, 32'd0);
      access(0, 0, 8'd2, 16'h0, r);
      chk("R11 all cleared", {31'd0, irq_n}, 32'd1);
   endtask

   initial begin
      #(200000 * 4);
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_rw();
      t_both();
      t_range();
      t_float();
      t_irq();
      repeat (2) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule